// File: doc/BRIEF.md
# Host-Side Serial Port Register Window

This block is a register-level model of a PC-style serial port as a host CPU sees it through an eight-byte I/O window. A 3-bit offset with separate read and write strobes selects one of the port's registers: the divisor latch, interrupt enable, interrupt identification, line control, modem control, line status, modem status and a scratch byte. No serial bit timing is produced. A byte the host writes to the transmit data register comes out at once on a byte-stream port. Bytes that arrive from outside are pushed into a receive queue, which the host drains through the same data offset.

An interrupt request line is driven from a small state machine with three states. `IRQ_IDLE` means nothing is pending (identification code 0x01). `IRQ_THRE` means the transmit holding register is empty (code 0x02). `IRQ_RDA` means received data is available (code 0x04). There are four transitions. *raise_thre* goes from `IRQ_IDLE` to `IRQ_THRE` on a transmitted byte while the transmit-empty enable is set. *raise_rda* goes from `IRQ_IDLE` or `IRQ_THRE` to `IRQ_RDA` on an accepted received byte while the receive enable is set. *hold_rda* keeps `IRQ_RDA` when a transmit event arrives. *ack* returns to `IRQ_IDLE` when the host reads the identification register. A read that coincides with a new event acknowledges first, so the event is not lost. In loopback mode, transmitted bytes are fed back into the receive queue and the modem status bits follow the modem control outputs.

Top module: `serwin_top`

## Requirements
- R1: After reset, reads return divisor low 0x0C, divisor high 0x00, offset 1 (IER) 0x00, offset 2 0xC1, offset 3 0x03, offset 4 0x08, offset 5 0x60, offset 6 0xB0 and offset 7 0x00. `irq` and `tx_valid` are low.
- R2: With bit 7 of the line control register (offset 3) set, offsets 0 and 1 read and write the divisor low and high bytes, and a write to offset 0 sends nothing. With that bit clear, offset 0 is the data register and offset 1 is the interrupt enable register.
- R3: A write to the interrupt enable register stores bits 3:0 of the written byte and stores bits 7:4 as zero.
- R4: A read of offset 2 returns the stored identification code ORed with 0xC0. The code then returns to 0x01 and `irq` falls, unless a new event arrives in the same cycle. Writes to offset 2 change nothing.
- R5: A data write with loopback (bit 4 of the modem control register) clear drives `tx_valid` high with the byte on `tx_data` for the following cycle. If enable bit 1 is set, the code becomes 0x02 and `irq` rises.
- R6: A data write with loopback set places the byte in the receive queue and leaves `tx_valid` low. It counts as a received byte for R10.
- R7: A data read with bit 7 of the line control register clear returns the oldest queued byte and removes it. Bytes come out in arrival order. An empty queue reads 0x00.
- R8: Line status bits 6 and 5 (transmitter idle, holding register empty) always read 1.
- R9: Offsets 3, 4 and 7 read back what was written. With loopback clear, offset 6 reads 0xB0.
- R10: An accepted received byte sets line status bit 0. If enable bit 0 is set, the code becomes 0x04 and `irq` rises. Bit 0 clears when the queue becomes empty.
- R11: With loopback set, offset 6 reads bit 7 = control bit 3, bit 6 = control bit 2, bit 5 = control bit 0, bit 4 = control bit 1, and bits 3:0 = 0.
- R12: The receive queue holds 16 bytes. A push into a full queue drops the byte and sets line status bit 1. A read of offset 5 clears that bit after returning it.
- R13: A received-data event outranks a transmit-empty event, both when they arrive in the same cycle and when transmit-empty arrives while received data is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` and current state |
| tx_valid | output | 1 | One-cycle pulse for each transmitted byte |
| tx_data | output | 8 | Transmitted byte, valid with `tx_valid` |
| rx_push | input | 1 | Push one received byte into the queue |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request, high while a cause is pending |

## Verification
Read data is combinational, so the bench samples `bus_rdata` in the same cycle the read strobe is high, between the falling and the rising edge. A read's side effects (popping the queue, acknowledging the interrupt, clearing overrun) land at the rising edge that ends that cycle. `tx_valid`, `tx_data`, `irq`, the line status bits and every register update become visible one edge after the write or push that caused them. The bench therefore checks them at the falling edge that follows that edge. Each access task returns at that falling edge, so a check written right after a task call always looks at the cycle in which the result is due.

// File: rtl/serwin_pkg.sv
package serwin_pkg;

    localparam int BYTE_W = 8;

    // Register offsets inside the eight-byte window
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IEN  = 3'd1;
    localparam logic [2:0] OFS_IID  = 3'd2;
    localparam logic [2:0] OFS_LCTL = 3'd3;
    localparam logic [2:0] OFS_MCTL = 3'd4;
    localparam logic [2:0] OFS_LSTA = 3'd5;
    localparam logic [2:0] OFS_MSTA = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    // Reset values
    localparam logic [7:0] RST_DIV_LO = 8'h0C;
    localparam logic [7:0] RST_DIV_HI = 8'h00;
    localparam logic [7:0] RST_IEN    = 8'h00;
    localparam logic [7:0] RST_LCTL   = 8'h03;
    localparam logic [7:0] RST_MCTL   = 8'h08;
    localparam logic [7:0] RST_SCR    = 8'h00;
    localparam logic [7:0] MSTA_IDLE  = 8'hB0;
    localparam logic [7:0] IID_FIFO   = 8'hC0;

    // Identification codes
    localparam logic [7:0] IID_NONE = 8'h01;
    localparam logic [7:0] IID_THRE = 8'h02;
    localparam logic [7:0] IID_RDA  = 8'h04;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_THRE = 2'd1,
        IRQ_RDA  = 2'd2
    } irq_state_e;

endpackage

// File: rtl/serwin_regs.sv
module serwin_regs
    import serwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] div_lo,
    output logic [BYTE_W-1:0] div_hi,
    output logic [BYTE_W-1:0] ien,
    output logic [BYTE_W-1:0] lctl,
    output logic [BYTE_W-1:0] mctl,
    output logic [BYTE_W-1:0] scr
);
    localparam int IEN_KEEP = 4;

    logic latch_sel;
    assign latch_sel = lctl[7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= RST_DIV_LO;
            div_hi <= RST_DIV_HI;
            ien    <= RST_IEN;
            lctl   <= RST_LCTL;
            mctl   <= RST_MCTL;
            scr    <= RST_SCR;
        end else if (wr_en) begin
            unique case (addr)
                OFS_DATA: if (latch_sel) div_lo <= wdata;
                OFS_IEN: begin
                    if (latch_sel) div_hi <= wdata;
                    else ien <= {{(BYTE_W-IEN_KEEP){1'b0}}, wdata[IEN_KEEP-1:0]};
                end
                OFS_LCTL: lctl <= wdata;
                OFS_MCTL: mctl <= wdata;
                OFS_SCR:  scr  <= wdata;
                default: ;
            endcase
        end
    end

    // R3: the upper enable bits never take written ones
    a_r3_ien_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_IEN && !latch_sel) |=> (ien[7:4] == 4'h0 && ien[3:0] == $past(wdata[3:0])));

    // R2: divisor writes only with the latch selector set
    a_r2_div_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA && !latch_sel) |=> $stable(div_lo));

endmodule

// File: rtl/serwin_rxq.sv
module serwin_rxq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dropped = push && !do_push;
    assign dout    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // R12: occupancy never exceeds the depth
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R12: a rejected push leaves the occupancy alone
    a_r12_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == FULL_CNT));

    // R7: a lone pop removes exactly one entry
    a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/serwin_irq.sv
module serwin_irq
    import serwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thre_evt,
    input  logic             rda_evt,
    input  logic             iid_rd,
    output logic [BYTE_W-1:0] iid_code,
    output logic             irq
);
    irq_state_e state, base, nxt;

    // An acknowledging read clears first; events in the same cycle then apply
    assign base = iid_rd ? IRQ_IDLE : state;

    always_comb begin
        nxt = base;
        unique case (base)
            IRQ_IDLE: begin
                if (rda_evt)       nxt = IRQ_RDA;   // raise_rda
                else if (thre_evt) nxt = IRQ_THRE;  // raise_thre
            end
            IRQ_THRE: begin
                if (rda_evt)       nxt = IRQ_RDA;   // raise_rda
            end
            IRQ_RDA: begin
                nxt = IRQ_RDA;                      // hold_rda
            end
            default: nxt = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            IRQ_THRE: begin iid_code = IID_THRE; irq = 1'b1; end
            IRQ_RDA:  begin iid_code = IID_RDA;  irq = 1'b1; end
            default:  begin iid_code = IID_NONE; irq = 1'b0; end
        endcase
    end

    // R13: a received-data event always wins
    a_r13_rda_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rda_evt |=> (state == IRQ_RDA));

    // R4: an acknowledge with no new event returns to idle
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && !rda_evt && !thre_evt) |=> (state == IRQ_IDLE && !irq));

    // R5: a lone transmit-empty event from idle raises the line
    a_r5_thre_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_evt && !rda_evt && (iid_rd || state == IRQ_IDLE)) |=> (state == IRQ_THRE && irq));

endmodule

// File: rtl/serwin_top.sv
module serwin_top
    import serwin_pkg::*;
#(
    parameter int RXQ_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    output logic       irq
);
    logic [7:0] div_lo, div_hi, ien, lctl, mctl, scr;
    logic [7:0] iid_code, lsta, msta, q_dout, q_din;
    logic       latch_sel, loop_on;
    logic       data_wr, data_rd, iid_rd, lsta_rd;
    logic       q_push, q_empty, q_full, q_drop;
    logic       thre_evt, rda_evt, overrun;

    serwin_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .div_lo (div_lo),
        .div_hi (div_hi),
        .ien    (ien),
        .lctl   (lctl),
        .mctl   (mctl),
        .scr    (scr)
    );

    assign latch_sel = lctl[7];
    assign loop_on   = mctl[4];
    assign data_wr   = bus_wr && bus_addr == OFS_DATA && !latch_sel;
    assign data_rd   = bus_rd && bus_addr == OFS_DATA && !latch_sel;
    assign iid_rd    = bus_rd && bus_addr == OFS_IID;
    assign lsta_rd   = bus_rd && bus_addr == OFS_LSTA;

    // Loopback writes own the queue's write port in their cycle
    assign q_push = (data_wr && loop_on) || rx_push;
    assign q_din  = (data_wr && loop_on) ? bus_wdata : rx_data;

    serwin_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .din     (q_din),
        .pop     (data_rd),
        .dout    (q_dout),
        .empty   (q_empty),
        .full    (q_full),
        .dropped (q_drop)
    );

    assign thre_evt = data_wr && !loop_on && ien[1];
    assign rda_evt  = q_push && !q_drop && ien[0];

    serwin_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .thre_evt (thre_evt),
        .rda_evt  (rda_evt),
        .iid_rd   (iid_rd),
        .iid_code (iid_code),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            overrun  <= 1'b0;
        end else begin
            tx_valid <= data_wr && !loop_on;
            if (data_wr && !loop_on) tx_data <= bus_wdata;
            if (q_drop)       overrun <= 1'b1;
            else if (lsta_rd) overrun <= 1'b0;
        end
    end

    assign lsta = {1'b0, 1'b1, 1'b1, 3'b000, overrun, !q_empty};
    assign msta = loop_on ? {mctl[3], mctl[2], mctl[0], mctl[1], 4'h0} : MSTA_IDLE;

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = latch_sel ? div_lo : q_dout;
            OFS_IEN:  bus_rdata = latch_sel ? div_hi : ien;
            OFS_IID:  bus_rdata = iid_code | IID_FIFO;
            OFS_LCTL: bus_rdata = lctl;
            OFS_MCTL: bus_rdata = mctl;
            OFS_LSTA: bus_rdata = lsta;
            OFS_MSTA: bus_rdata = msta;
            default:  bus_rdata = scr;
        endcase
    end

    // R5: a transmitted byte appears one cycle after its write
    a_r5_tx_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !loop_on) |=> (tx_valid && tx_data == $past(bus_wdata)));

    // R6: a loopback write never reaches the output stream
    a_r6_loop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && loop_on) |=> !tx_valid);

    // R12: a dropped byte flags overrun
    a_r12_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        q_drop |=> overrun);

    // R10: data-ready follows the queue after an accepted push
    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && !q_drop) |=> lsta[0]);

endmodule

// File: tb/tb_serwin_top.sv
module tb_serwin_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serwin_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_push(rx_push),
        .rx_data(rx_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        rd_chk("R1 ien", 3'd1, 8'h00);
        rd_chk("R1 iid", 3'd2, 8'hC1);
        rd_chk("R1 lctl", 3'd3, 8'h03);
        rd_chk("R1 mctl", 3'd4, 8'h08);
        rd_chk("R1 lsta", 3'd5, 8'h60);
        rd_chk("R1 msta", 3'd6, 8'hB0);
        rd_chk("R1 scr", 3'd7, 8'h00);
        wr(3'd3, 8'h83);
        rd_chk("R1 div_lo", 3'd0, 8'h0C);
        rd_chk("R1 div_hi", 3'd1, 8'h00);
    endtask

    task automatic t_divisor();
        wr(3'd0, 8'h34);
        chk("R2 no tx on divisor write", {7'd0, tx_valid}, 8'h00);
        wr(3'd1, 8'h12);
        rd_chk("R2 div_lo", 3'd0, 8'h34);
        rd_chk("R2 div_hi", 3'd1, 8'h12);
        wr(3'd3, 8'h03);
        rd_chk("R2 offset1 is ien", 3'd1, 8'h00);
        wr(3'd3, 8'h83);
        rd_chk("R2 div_lo kept", 3'd0, 8'h34);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_ien_mask();
        wr(3'd1, 8'hFF);
        rd_chk("R3 ien mask", 3'd1, 8'h0F);
        wr(3'd1, 8'hA6);
        rd_chk("R3 ien mask 2", 3'd1, 8'h06);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_plain_regs();
        wr(3'd7, 8'hA5);
        rd_chk("R9 scr", 3'd7, 8'hA5);
        wr(3'd4, 8'h0B);
        rd_chk("R9 mctl", 3'd4, 8'h0B);
        rd_chk("R9 msta no loop", 3'd6, 8'hB0);
        wr(3'd4, 8'h08);
        wr(3'd3, 8'h1B);
        rd_chk("R9 lctl", 3'd3, 8'h1B);
        wr(3'd3, 8'h03);
        wr(3'd2, 8'h55);
        rd_chk("R4 iid write ignored", 3'd2, 8'hC1);
    endtask

    task automatic t_transmit();
        wr(3'd0, 8'h41);
        chk("R5 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R5 tx_data", tx_data, 8'h41);
        chk("R5 no irq when disabled", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R5 tx_valid one cycle", {7'd0, tx_valid}, 8'h00);
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h42);
        chk("R5 tx_data 2", tx_data, 8'h42);
        chk("R5 irq raised", {7'd0, irq}, 8'h01);
        rd_chk("R4 iid thre", 3'd2, 8'hC2);
        chk("R4 irq cleared", {7'd0, irq}, 8'h00);
        rd_chk("R4 iid back to none", 3'd2, 8'hC1);
        rd_chk("R8 lsta after tx", 3'd5, 8'h60);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_receive();
        wr(3'd1, 8'h01);
        push(8'h61);
        chk("R10 irq", {7'd0, irq}, 8'h01);
        rd_chk("R10 lsta ready", 3'd5, 8'h61);
        rd_chk("R10 iid rda", 3'd2, 8'hC4);
        rd_chk("R7 data", 3'd0, 8'h61);
        rd_chk("R10 ready cleared", 3'd5, 8'h60);
        rd_chk("R7 empty read", 3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
        push(8'hEE);
        rd_chk("R12 overrun set", 3'd5, 8'h63);
        rd_chk("R12 overrun cleared by read", 3'd5, 8'h61);
        for (int i = 0; i < 16; i++) rd_chk("R7 order", 3'd0, 8'(i * 3 + 1));
        rd_chk("R12 dropped byte absent", 3'd5, 8'h60);
    endtask

    task automatic t_loopback();
        wr(3'd4, 8'h15);
        rd_chk("R11 msta loop", 3'd6, 8'h60);
        wr(3'd4, 8'h1A);
        rd_chk("R11 msta loop 2", 3'd6, 8'h90);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h77);
        chk("R6 no tx", {7'd0, tx_valid}, 8'h00);
        chk("R6 irq from loop byte", {7'd0, irq}, 8'h01);
        rd_chk("R6 lsta ready", 3'd5, 8'h61);
        rd_chk("R6 looped byte", 3'd0, 8'h77);
        rd_chk("R6 iid rda", 3'd2, 8'hC4);
        wr(3'd4, 8'h08);
        rd_chk("R9 msta restored", 3'd6, 8'hB0);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_priority();
        wr(3'd1, 8'h03);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h50; bus_wr = 1'b1;
        rx_data = 8'h99; rx_push = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_push = 1'b0;
        chk("R13 tx still sent", tx_data, 8'h50);
        rd_chk("R13 same cycle rda wins", 3'd2, 8'hC4);
        push(8'h98);
        wr(3'd0, 8'h51);
        rd_chk("R13 held rda", 3'd2, 8'hC4);
        rd_chk("R7 drain 1", 3'd0, 8'h99);
        rd_chk("R7 drain 2", 3'd0, 8'h98);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisor();
        t_ien_mask();
        t_plain_regs();
        t_transmit();
        t_receive();
        t_overrun();
        t_loopback();
        t_priority();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule